// File: doc/BRIEF.md
# Tensor Mode-n Unfolding Reshaper

This block reorders the elements of a small third-order tensor so that it can be used as a matrix. A start pulse captures three dimensions and a mode code. The block first copies every element from a source memory into a local buffer. The copy reads the source at consecutive addresses, one per cycle, and the source memory has a fixed one-cycle read latency. Once the copy is complete, the block walks the tensor in column-major order (first index fastest) and writes each element to a destination memory. The destination address is the element's position in the requested unfolded matrix, which is stored row-major.

Three mode codes select the mode-1, mode-2 or mode-3 unfolding of a tensor held in column-major order. A fourth code takes a source that already holds the mode-2 unfolded matrix, stored row-major, and writes the mode-1 unfolding of the same tensor. A multiply-free nested counter drives two address accumulators, one for the buffer read and one for the destination write. Their strides are derived once from the captured configuration.

Top module: `tensor_unfold`

## Requirements
- R1: With zero-based indices (i1,i2,i3), the source holds element (i1,i2,i3) at address i1 + I1*i2 + I1*I2*i3. With mode_sel = 0, that element is written to destination address i1*(I2*I3) + i2 + I2*i3.
- R2: With mode_sel = 1, element (i1,i2,i3) of the column-major source is written to destination address i2*(I1*I3) + i1 + I1*i3.
- R3: With mode_sel = 2, element (i1,i2,i3) of the column-major source is written to destination address i3*(I1*I2) + i1 + I1*i2.
- R4: With mode_sel = 3, the source holds element (i1,i2,i3) at address i2*(I1*I3) + i1 + I1*i3, and the element is written to destination address i1*(I2*I3) + i2 + I2*i3.
- R5: Every source read comes before any destination write. The reads are issued on consecutive cycles at addresses 0 to N-1 in increasing order, where N = I1*I2*I3. Each data word is taken one cycle after its read.
- R6: A run writes each destination address from 0 to N-1 exactly once and writes no address at or above N.
- R7: done is high for exactly one cycle, in the cycle after the last destination write. busy is high from the cycle after an accepted start until that last write.
- R8: A start pulse while busy is high is ignored. The run in progress completes with its captured mode and dimensions, and only one done pulse is produced.
- R9: A dimension of 1 on any axis, including the 1x1x1 case, yields a correct reshape. Dimensions must be nonzero and have a product of at most DEPTH.
- R10: After reset, busy, done, src_rd and dst_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; captured only while idle |
| mode_sel | input | 2 | 0: mode-1, 1: mode-2, 2: mode-3, 3: mode-2 matrix to mode-1 |
| dim1 | input | DIM_W | Tensor size along the first index |
| dim2 | input | DIM_W | Tensor size along the second index |
| dim3 | input | DIM_W | Tensor size along the third index |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_rd | output | 1 | Source read request |
| src_addr | output | ADDR_W | Source read address |
| src_data | input | DATA_W | Source read data, valid one cycle after src_rd |
| dst_we | output | 1 | Destination write enable |
| dst_addr | output | ADDR_W | Destination write address |
| dst_data | output | DATA_W | Destination write data |

## Verification
The bench targets shapes where one or more axes are 1. Here the wrap conditions of inner counters coincide, and a design that mishandles a simultaneous double wrap would skip or repeat elements. It also targets the full-depth cube, where an address width or count error would truncate addresses or drop the final element. Each destination word is compared with a value that encodes its tensor coordinates, so a swapped stride or a wrong conversion order is caught at the first misplaced element. Write counts per address catch duplicated or missing writes. A start pulse issued mid-run with a different configuration must leave the result and the single done pulse unchanged.

// File: rtl/tu_pkg.sv
package tu_pkg;

   typedef enum logic [1:0] {
      TU_MODE1    = 2'd0,
      TU_MODE2    = 2'd1,
      TU_MODE3    = 2'd2,
      TU_M2_TO_M1 = 2'd3
   } tu_mode_e;

   typedef enum logic [2:0] {
      TU_IDLE   = 3'd0,
      TU_LOAD   = 3'd1,
      TU_SETTLE = 3'd2,
      TU_WALK   = 3'd3,
      TU_TAIL   = 3'd4
   } tu_state_e;

endpackage

// File: rtl/tu_stride_sel.sv
module tu_stride_sel
   import tu_pkg::*;
#(
   parameter int DIM_W = 4,
   parameter int CNT_W = 7
) (
   input  tu_mode_e                 mode,
   input  logic [DIM_W-1:0]         d1,
   input  logic [DIM_W-1:0]         d2,
   input  logic [DIM_W-1:0]         d3,
   output logic [2:0][CNT_W-1:0]    rd_stride,
   output logic [2:0][CNT_W-1:0]    wr_stride,
   output logic [CNT_W-1:0]         volume
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] e1, e2, e3, p12, p13, p23;

   assign e1  = CNT_W'(d1);
   assign e2  = CNT_W'(d2);
   assign e3  = CNT_W'(d3);
   assign p12 = e1 * e2;
   assign p13 = e1 * e3;
   assign p23 = e2 * e3;
   assign volume = p12 * e3;

   // index order of each stride vector: [0] first index, [1] second, [2] third
   always_comb begin
      if (mode == TU_M2_TO_M1) begin
         rd_stride = {e1, p13, ONE};
      end else begin
         rd_stride = {p12, e1, ONE};
      end
      unique case (mode)
         TU_MODE2: wr_stride = {e1, p13, ONE};
         TU_MODE3: wr_stride = {p12, e1, ONE};
         default:  wr_stride = {e2, ONE, p23};
      endcase
   end

endmodule

// File: rtl/tu_index_ctr.sv
module tu_index_ctr #(
   parameter int DIM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [DIM_W-1:0] d1,
   input  logic [DIM_W-1:0] d2,
   input  logic [DIM_W-1:0] d3,
   output logic             adv_b,
   output logic             adv_c,
   output logic             last
);

   logic [DIM_W-1:0] i1, i2, i3;
   logic             wrap1, wrap2, wrap3;

   assign wrap1 = (i1 == d1 - DIM_W'(1));
   assign wrap2 = (i2 == d2 - DIM_W'(1));
   assign wrap3 = (i3 == d3 - DIM_W'(1));
   assign adv_b = step && wrap1 && !wrap2;
   assign adv_c = step && wrap1 && wrap2;
   assign last  = wrap1 && wrap2 && wrap3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i1 <= '0;
         i2 <= '0;
         i3 <= '0;
      end else if (clr) begin
         i1 <= '0;
         i2 <= '0;
         i3 <= '0;
      end else if (step) begin
         if (!wrap1) begin
            i1 <= i1 + DIM_W'(1);
         end else if (!wrap2) begin
            i1 <= '0;
            i2 <= i2 + DIM_W'(1);
         end else begin
            i1 <= '0;
            i2 <= '0;
            i3 <= i3 + DIM_W'(1);
         end
      end
   end

   // R6: the walk never leaves the tensor volume
   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (i1 < d1) && (i2 < d2) && (i3 < d3));

endmodule

// File: rtl/tu_addr_acc.sv
module tu_addr_acc #(
   parameter int CNT_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   step,
   input  logic                   adv_b,
   input  logic                   adv_c,
   input  logic [2:0][CNT_W-1:0]  stride,
   output logic [CNT_W-1:0]       addr
);

   logic [CNT_W-1:0] base_b, base_c, next_b, next_c;

   assign next_b = base_b + stride[1];
   assign next_c = base_c + stride[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         base_b <= '0;
         base_c <= '0;
      end else if (clr) begin
         addr   <= '0;
         base_b <= '0;
         base_c <= '0;
      end else if (adv_c) begin
         addr   <= next_c;
         base_b <= next_c;
         base_c <= next_c;
      end else if (adv_b) begin
         addr   <= next_b;
         base_b <= next_b;
      end else if (step) begin
         addr   <= addr + stride[0];
      end
   end

endmodule

// File: rtl/tensor_unfold.sv
module tensor_unfold
   import tu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int DIM_W  = 4,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode_sel,
   input  logic [DIM_W-1:0]  dim1,
   input  logic [DIM_W-1:0]  dim2,
   input  logic [DIM_W-1:0]  dim3,
   output logic              busy,
   output logic              done,
   output logic              src_rd,
   output logic [ADDR_W-1:0] src_addr,
   input  logic [DATA_W-1:0] src_data,
   output logic              dst_we,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [DATA_W-1:0] dst_data
);

   localparam int VOL_W = 3 * DIM_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tensor_unfold: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("tensor_unfold: DATA_W must be positive");
      end
      if (DIM_W < 1 || DIM_W > CNT_W + 4) begin : g_bad_dim
         $error("tensor_unfold: DIM_W out of range for DEPTH");
      end
   endgenerate

   tu_state_e             state;
   tu_mode_e              cfg_mode;
   logic [DIM_W-1:0]      cfg_d1, cfg_d2, cfg_d3;
   logic [CNT_W-1:0]      ld_cnt, n_tot;
   logic                  rd_d;
   logic [ADDR_W-1:0]     ld_wa;
   logic                  we_q, done_q;
   logic [ADDR_W-1:0]     dst_addr_q;
   logic [DATA_W-1:0]     buf_q;
   logic [DATA_W-1:0]     buf_mem [DEPTH];

   logic [1:0][2:0][CNT_W-1:0] strd;
   logic [1:0][CNT_W-1:0]      acc;
   logic                       walk_step, walk_clr, adv_b, adv_c, walk_last;
   logic [VOL_W-1:0]           in_vol;

   assign walk_step = (state == TU_WALK);
   assign walk_clr  = (state == TU_SETTLE);
   assign in_vol    = VOL_W'(dim1) * VOL_W'(dim2) * VOL_W'(dim3);

   tu_stride_sel #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_stride (
      .mode      (cfg_mode),
      .d1        (cfg_d1),
      .d2        (cfg_d2),
      .d3        (cfg_d3),
      .rd_stride (strd[0]),
      .wr_stride (strd[1]),
      .volume    (n_tot)
   );

   tu_index_ctr #(.DIM_W(DIM_W)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (walk_clr),
      .step  (walk_step),
      .d1    (cfg_d1),
      .d2    (cfg_d2),
      .d3    (cfg_d3),
      .adv_b (adv_b),
      .adv_c (adv_c),
      .last  (walk_last)
   );

   // one accumulator for the buffer read side, one for the destination side
   for (genvar g = 0; g < 2; g++) begin : g_acc
      tu_addr_acc #(.CNT_W(CNT_W)) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (walk_clr),
         .step   (walk_step),
         .adv_b  (adv_b),
         .adv_c  (adv_c),
         .stride (strd[g]),
         .addr   (acc[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TU_IDLE;
         cfg_mode   <= TU_MODE1;
         cfg_d1     <= DIM_W'(1);
         cfg_d2     <= DIM_W'(1);
         cfg_d3     <= DIM_W'(1);
         ld_cnt     <= '0;
         rd_d       <= 1'b0;
         ld_wa      <= '0;
         we_q       <= 1'b0;
         done_q     <= 1'b0;
         dst_addr_q <= '0;
      end else begin
         rd_d   <= (state == TU_LOAD);
         ld_wa  <= ld_cnt[ADDR_W-1:0];
         we_q   <= (state == TU_WALK);
         done_q <= (state == TU_TAIL);
         unique case (state)
            TU_IDLE: begin
               if (start) begin
                  cfg_mode <= tu_mode_e'(mode_sel);
                  cfg_d1   <= dim1;
                  cfg_d2   <= dim2;
                  cfg_d3   <= dim3;
                  ld_cnt   <= '0;
                  state    <= TU_LOAD;
               end
            end
            TU_LOAD: begin
               if (ld_cnt == n_tot - CNT_W'(1)) begin
                  state <= TU_SETTLE;
               end else begin
                  ld_cnt <= ld_cnt + CNT_W'(1);
               end
            end
            TU_SETTLE: state <= TU_WALK;
            TU_WALK: begin
               dst_addr_q <= acc[1][ADDR_W-1:0];
               if (walk_last) begin
                  state <= TU_TAIL;
               end
            end
            TU_TAIL: state <= TU_IDLE;
            default: state <= TU_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rd_d) begin
         buf_mem[ld_wa] <= src_data;
      end
      if (walk_step) begin
         buf_q <= buf_mem[acc[0][ADDR_W-1:0]];
      end
   end

   assign busy     = (state != TU_IDLE);
   assign done     = done_q;
   assign src_rd   = (state == TU_LOAD);
   assign src_addr = ld_cnt[ADDR_W-1:0];
   assign dst_we   = we_q;
   assign dst_addr = dst_addr_q;
   assign dst_data = buf_q;

   assert_cfg_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (dim1 != '0) && (dim2 != '0) && (dim3 != '0)
                           && (in_vol <= VOL_W'(DEPTH)));

   assert_no_write_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd |-> !dst_we);

   assert_src_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rd && $past(src_rd)) |-> (src_addr == $past(src_addr) + ADDR_W'(1)));

   assert_src_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd |-> (CNT_W'(src_addr) < n_tot));

   assert_walk_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      walk_step |-> (acc[0] < n_tot) && (acc[1] < n_tot));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(dst_we) && !dst_we && !busy));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(cfg_mode) && $stable(cfg_d1)
                           && $stable(cfg_d2) && $stable(cfg_d3)));

endmodule

// File: tb/tensor_unfold_tb.sv
module tensor_unfold_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int DEPTH = 64;
   localparam int DIMW  = 4;
   localparam int AW    = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      mode_sel = 2'd0;
   logic [DIMW-1:0] dim1 = 4'd1, dim2 = 4'd1, dim3 = 4'd1;
   logic            busy, done, src_rd, dst_we;
   logic [AW-1:0]   src_addr, dst_addr;
   logic [DW-1:0]   src_data, dst_data;

   logic [DW-1:0]   smem [DEPTH];
   logic [DW-1:0]   dmem [DEPTH];
   int              wcnt [DEPTH];
   logic            clr_mon = 1'b0;

   int  exp_rd, done_cnt;
   bit  rd_order_err, wr_before_rd_err, pulse_err, done_pos_err, wr_seen, prev_done, prev_we;
   int  n_checks = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tensor_unfold #(.DATA_W(DW), .DEPTH(DEPTH), .DIM_W(DIMW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
      .dim1(dim1), .dim2(dim2), .dim3(dim3), .busy(busy), .done(done),
      .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
      .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data)
   );

   // source memory with one cycle of read latency
   always @(posedge clk) begin
      if (src_rd) src_data <= smem[src_addr];
   end

   // destination memory and protocol monitor
   always @(posedge clk) begin
      if (clr_mon) begin
         for (int k = 0; k < DEPTH; k++) begin
            dmem[k] <= 16'hDEAD;
            wcnt[k] <= 0;
         end
         exp_rd <= 0; done_cnt <= 0; rd_order_err <= 0; wr_before_rd_err <= 0;
         pulse_err <= 0; done_pos_err <= 0; wr_seen <= 0; prev_done <= 0; prev_we <= 0;
      end else begin
         if (dst_we) begin
            dmem[dst_addr] <= dst_data;
            wcnt[dst_addr] <= wcnt[dst_addr] + 1;
            wr_seen <= 1'b1;
         end
         if (src_rd) begin
            if (int'(src_addr) != exp_rd) rd_order_err <= 1'b1;
            if (wr_seen || dst_we) wr_before_rd_err <= 1'b1;
            exp_rd <= exp_rd + 1;
         end
         if (done) begin
            done_cnt <= done_cnt + 1;
            if (prev_done) pulse_err <= 1'b1;
            if (!prev_we || dst_we || busy) done_pos_err <= 1'b1;
         end
         prev_done <= done;
         prev_we   <= dst_we;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] val(int i1, int i2, int i3, int seed);
      return DW'(seed * 4096 + i1 * 256 + i2 * 16 + i3);
   endfunction

   function automatic string req_of(int m);
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic run(input int m, input int a, input int b, input int c, input int seed,
                      input bit disturb);
      int n, cyc, sa, da;
      string rq;
      n = a * b * c;
      rq = req_of(m);
      for (int k = 0; k < DEPTH; k++) smem[k] = 16'hBEEF;
      for (int i3 = 0; i3 < c; i3++)
         for (int i2 = 0; i2 < b; i2++)
            for (int i1 = 0; i1 < a; i1++) begin
               sa = (m == 3) ? i2 * (a * c) + i1 + a * i3 : i1 + a * i2 + a * b * i3;
               smem[sa] = val(i1, i2, i3, seed);
            end
      @(negedge clk); clr_mon = 1'b1;
      @(negedge clk); clr_mon = 1'b0;
      mode_sel = 2'(m); dim1 = DIMW'(a); dim2 = DIMW'(b); dim3 = DIMW'(c);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
      if (disturb) begin
         @(negedge clk);
         mode_sel = 2'((m + 1) % 4); dim1 = 4'd1; dim2 = 4'd1; dim3 = 4'd1; start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      cyc = 0;
      while (done_cnt == 0 && cyc < 1000) begin
         @(negedge clk); cyc++;
      end
      repeat (4) @(negedge clk);
      chk(cyc < 1000, "R7 done arrives", cyc, 0);
      chk(done_cnt == 1, disturb ? "R8 single done" : "R7 single done", done_cnt, 1);
      chk(!pulse_err && !done_pos_err, "R7 done one cycle after last write",
          int'(pulse_err) * 2 + int'(done_pos_err), 0);
      chk(!rd_order_err && exp_rd == n, "R5 sequential source reads", exp_rd, n);
      chk(!wr_before_rd_err, "R5 reads before writes", int'(wr_before_rd_err), 0);
      for (int i3 = 0; i3 < c; i3++)
         for (int i2 = 0; i2 < b; i2++)
            for (int i1 = 0; i1 < a; i1++) begin
               case (m)
                  1: da = i2 * (a * c) + i1 + a * i3;
                  2: da = i3 * (a * b) + i1 + a * i2;
                  default: da = i1 * (b * c) + i2 + b * i3;
               endcase
               chk(dmem[da] == val(i1, i2, i3, seed),
                   (a == 1 || b == 1 || c == 1) ? {rq, " R9 unit dim"}
                                                : (disturb ? {rq, " R8"} : rq),
                   int'(dmem[da]), int'(val(i1, i2, i3, seed)));
            end
      for (int k = 0; k < DEPTH; k++) begin
         if (k < n) chk(wcnt[k] == 1, "R6 one write per address", wcnt[k], 1);
         else if (wcnt[k] != 0) chk(1'b0, "R6 no write above N", wcnt[k], 0);
      end
   endtask

   initial begin
      int sa [7] = '{2, 4, 1, 1, 3, 4, 5};
      int sb [7] = '{3, 1, 1, 5, 3, 4, 2};
      int sc [7] = '{4, 3, 1, 1, 3, 4, 1};
      repeat (3) @(negedge clk);
      chk(!busy && !done && !src_rd && !dst_we, "R10 reset state",
          int'({busy, done, src_rd, dst_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !src_rd && !dst_we, "R10 idle after reset",
          int'({busy, done, src_rd, dst_we}), 0);
      for (int s = 0; s < 7; s++)
         for (int m = 0; m < 4; m++)
            run(m, sa[s], sb[s], sc[s], (s + m) % 16, 1'b0);
      run(0, 3, 2, 4, 9, 1'b1);
      run(3, 2, 4, 3, 5, 1'b1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule